// File: doc/BRIEF.md
# ADC Offset Compensation Averager

This calibration unit measures the offset of an analog-to-digital converter while the conversion engine is held in its compensation condition, where the converter input is forced to half of the reference. After a start pulse it waits out a settling interval. It then collects a fixed set of fresh 10-bit conversions from the calibration channel, averages them with a shift, and reports how far that average lies from midscale as a signed correction.

Software reads the correction, or later logic adds it to ordinary results. The unit runs once per start pulse. It raises busy for the whole run and pulses done when the correction is updated. The correction register keeps its value between runs.

Top module: `adc_offset_cal`

## Requirements
- R1: After reset, busy_o is 0, done_o is 0 and comp_o is 0.
- R2: A start_i pulse while idle raises busy_o on the next clock edge. A start_i pulse while busy_o is 1 is ignored: the run continues with its own samples and produces exactly one done_o.
- R3: For the first SETTLE_CYC clock cycles after busy_o rises, valid samples are ignored and do not enter the average.
- R4: Only samples whose smp_chan_i equals CAL_CH (default 0) are accumulated; samples tagged with any other channel are ignored.
- R5: A sample counts only in the cycle where smp_valid_i rises from 0 to 1, so a valid held high for several cycles contributes one sample.
- R6: Exactly 16 accepted samples are summed without overflow, and the average is the sum shifted right by 4 (floor).
- R7: comp_o equals 512 minus the average, as an 11-bit two's-complement value in the range -511 to 512.
- R8: done_o is high for exactly one cycle, on the clock edge after the 16th accepted sample, and busy_o falls on that same edge.
- R9: comp_o changes only when done_o rises, and holds its value during later runs until the next result is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a calibration run (pulse) |
| smp_valid_i | input | 1 | A new conversion result is presented |
| smp_chan_i | input | CH_W | Channel that the presented result belongs to |
| smp_data_i | input | 10 | Conversion result |
| busy_o | output | 1 | Calibration run in progress |
| done_o | output | 1 | One-cycle pulse when comp_o is updated |
| comp_o | output | 11 | Signed compensation value (midscale minus average) |

## Verification
The bound checker watches, on every cycle, that no sample is taken before the settling window has elapsed, that every taken sample carries the calibration channel, that no run takes more than 16 samples and that done arrives only after exactly 16. It also checks that done lasts one cycle and coincides with busy falling, that the correction moves only when done is raised, and that it stays within the midscale range. The arithmetic values themselves can only be shown by the bench scenarios. These include uniform midscale, zero and full-scale inputs, a ramp whose sum is not a multiple of 16, and a run full of decoys: samples during settling, samples tagged with other channels, held valids and a second start. A wrong sample in any of those cases shifts the expected correction.

// File: rtl/adc_cal_pkg.sv
package adc_cal_pkg;
  parameter int unsigned SMP_W     = 10;
  parameter int unsigned AVG_SHIFT = 4;
  localparam int unsigned ACC_W    = SMP_W + AVG_SHIFT;
  localparam int unsigned CMP_W    = SMP_W + 1;

  typedef logic [SMP_W-1:0]        smp_t;
  typedef logic [ACC_W-1:0]        acc_t;
  typedef logic signed [CMP_W-1:0] cmp_t;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_ACCUM  = 2'd2
  } cal_state_e;

  // Floor average of a full set of samples.
  function automatic smp_t avg_of(input acc_t sum);
    return sum[ACC_W-1:AVG_SHIFT];
  endfunction

  // Midscale minus the average, signed.
  function automatic cmp_t comp_of(input smp_t avg);
    return cmp_t'(1 << (SMP_W - 1)) - cmp_t'({1'b0, avg});
  endfunction
endpackage

// File: rtl/adc_cal_settle.sv
module adc_cal_settle #(
  parameter int unsigned SETTLE_CYC = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CNT_W = $clog2(SETTLE_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  assign expired_o = run_i && (cnt_q == CNT_W'(SETTLE_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (!run_i)    cnt_q <= '0;
    else if (!expired_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_cal_sampler.sv
module adc_cal_sampler #(
  parameter int unsigned CH_W   = 4,
  parameter int unsigned CAL_CH = 0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            valid_i,
  input  logic [CH_W-1:0] chan_i,
  output logic            take_o
);
  logic valid_q;

  // Fresh conversion: rising edge of valid, on the calibration channel.
  assign take_o = en_i && valid_i && !valid_q && (chan_i == CH_W'(CAL_CH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_i;
  end
endmodule

// File: rtl/adc_cal_accum.sv
module adc_cal_accum
  import adc_cal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic take_i,
  input  smp_t data_i,
  output acc_t sum_o,
  output logic last_o
);
  acc_t                 acc_q;
  logic [AVG_SHIFT-1:0] cnt_q;

  assign sum_o  = acc_q + acc_t'(data_i);
  assign last_o = take_i && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (take_i) begin
      acc_q <= sum_o;
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_offset_cal.sv
module adc_offset_cal
  import adc_cal_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 100000,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned CAL_CH     = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             smp_valid_i,
  input  logic [CH_W-1:0]  smp_chan_i,
  input  logic [SMP_W-1:0] smp_data_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CMP_W-1:0] comp_o
);
  cal_state_e state_q;

  logic start_acc_w;
  logic settle_done_w;
  logic take_w;
  logic last_w;
  acc_t sum_w;

  assign start_acc_w = (state_q == ST_IDLE) && start_i;
  assign busy_o      = (state_q != ST_IDLE);

  adc_cal_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (state_q == ST_SETTLE),
    .expired_o (settle_done_w)
  );

  adc_cal_sampler #(.CH_W(CH_W), .CAL_CH(CAL_CH)) u_sampler (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (state_q == ST_ACCUM),
    .valid_i (smp_valid_i),
    .chan_i  (smp_chan_i),
    .take_o  (take_w)
  );

  adc_cal_accum u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (state_q == ST_IDLE),
    .take_i (take_w),
    .data_i (smp_data_i),
    .sum_o  (sum_w),
    .last_o (last_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_o  <= 1'b0;
      comp_o  <= '0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE:   if (start_acc_w)   state_q <= ST_SETTLE;
        ST_SETTLE: if (settle_done_w) state_q <= ST_ACCUM;
        ST_ACCUM: begin
          if (last_w) begin
            state_q <= ST_IDLE;
            comp_o  <= comp_of(avg_of(sum_w));
            done_o  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_cal_chk.sv
module adc_cal_chk
  import adc_cal_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 100000,
  parameter int unsigned CH_W       = 4,
  parameter int unsigned CAL_CH     = 0
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CH_W-1:0]  smp_chan_i,
  input logic             busy_o,
  input logic             done_o,
  input logic [CMP_W-1:0] comp_o,
  input logic             take_w
);
  localparam int unsigned WIN_W = $clog2(SETTLE_CYC + 1);
  localparam int unsigned NSMP  = 1 << AVG_SHIFT;

  logic [WIN_W-1:0]   since_q;
  logic [AVG_SHIFT:0] nsmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          since_q <= '0;
    else if (!busy_o)                    since_q <= '0;
    else if (since_q < WIN_W'(SETTLE_CYC)) since_q <= since_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nsmp_q <= '0;
    else if (done_o) nsmp_q <= '0;
    else if (take_w) nsmp_q <= nsmp_q + 1'b1;
  end

  // R3
  settle_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> (busy_o && since_q >= WIN_W'(SETTLE_CYC)));

  // R4
  cal_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> (smp_chan_i == CH_W'(CAL_CH)));

  // R6
  no_extra_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> (nsmp_q < (AVG_SHIFT+1)'(NSMP)));

  // R6
  full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (nsmp_q == (AVG_SHIFT+1)'(NSMP)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R9
  comp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(comp_o));

  // R7
  comp_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($signed(comp_o) >= -511 && $signed(comp_o) <= 512));
endmodule

bind adc_offset_cal adc_cal_chk #(
  .SETTLE_CYC(SETTLE_CYC), .CH_W(CH_W), .CAL_CH(CAL_CH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_chan_i(smp_chan_i), .busy_o(busy_o),
  .done_o(done_o), .comp_o(comp_o), .take_w(take_w)
);

// File: tb/tb_adc_offset_cal.sv
`timescale 1ns/1ps
module tb_adc_offset_cal;
  localparam int SETTLE = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [3:0]  smp_chan_i = '0;
  logic [9:0]  smp_data_i = '0;
  logic        busy_o;
  logic        done_o;
  logic [10:0] comp_o;

  int errors = 0;
  int checks = 0;
  int exp_q[$];
  int last_comp = 0;
  bit prev_done = 1'b0;

  always #2.5 clk = ~clk;

  adc_offset_cal #(.SETTLE_CYC(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_valid_i(smp_valid_i),
    .smp_chan_i(smp_chan_i), .smp_data_i(smp_data_i), .busy_o(busy_o),
    .done_o(done_o), .comp_o(comp_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: pops expected corrections as results appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (done_o) begin
        chk(!prev_done, "R8 done one cycle", 1, 0);
        chk(!busy_o, "R8 busy falls with done", int'(busy_o), 0);
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected done", 1, 0);
        else begin
          int e;
          e = exp_q.pop_front();
          chk($signed(comp_o) == e, "R7 R6 correction", int'($signed(comp_o)), e);
          last_comp = e;
        end
      end
      prev_done = done_o;
    end
  end

  task automatic pulse(input int ch, input int val, input int hold);
    @(negedge clk);
    smp_valid_i = 1'b1; smp_chan_i = 4'(ch); smp_data_i = 10'(val);
    repeat (hold) @(negedge clk);
    smp_valid_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_cal(input int vals[16], input bit noisy);
    int sum = 0;
    for (int i = 0; i < 16; i++) sum += vals[i];
    exp_q.push_back(512 - (sum >> 4));
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o, "R2 busy after start", int'(busy_o), 1);
    chk($signed(comp_o) == last_comp, "R9 hold at start", int'($signed(comp_o)), last_comp);
    if (noisy) begin
      // R3: decoys during settling
      pulse(0, 0, 1); pulse(0, 0, 1); pulse(0, 0, 1);
      repeat (SETTLE - 4) @(negedge clk);
    end else begin
      repeat (SETTLE + 2) @(negedge clk);
    end
    for (int i = 0; i < 16; i++) begin
      if (noisy) begin
        pulse(3, 0, 1);           // R4 decoy channel
        pulse(0, vals[i], 3);     // R5 held valid
        if (i == 8) begin         // R2 start while busy
          start_i = 1'b1; @(negedge clk); start_i = 1'b0;
          chk($signed(comp_o) == last_comp, "R9 hold mid run", int'($signed(comp_o)), last_comp);
        end
      end else begin
        pulse(0, vals[i], 1);
      end
    end
    for (int t = 0; t < 10 && busy_o; t++) @(negedge clk);
    chk(!busy_o, "R8 idle after run", int'(busy_o), 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R6 result produced", exp_q.size(), 0);
  endtask

  initial begin
    int v[16];
    repeat (3) @(negedge clk);
    chk(!busy_o, "R1 busy reset", int'(busy_o), 0);
    chk(!done_o, "R1 done reset", int'(done_o), 0);
    chk(comp_o == 0, "R1 comp reset", int'(comp_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 16; i++) v[i] = 512;
    run_cal(v, 1'b0);
    for (int i = 0; i < 16; i++) v[i] = 0;
    run_cal(v, 1'b0);
    for (int i = 0; i < 16; i++) v[i] = 1023;
    run_cal(v, 1'b0);
    for (int i = 0; i < 16; i++) v[i] = 300 + i * 37;
    run_cal(v, 1'b0);
    for (int i = 0; i < 16; i++) v[i] = 500 + i;
    run_cal(v, 1'b1);

    repeat (20) @(negedge clk);
    chk($signed(comp_o) == last_comp, "R9 hold idle", int'($signed(comp_o)), last_comp);
    chk(!busy_o, "R2 no rerun from ignored start", int'(busy_o), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule